// File: doc/BRIEF.md
# Paged external data memory unit

This block is the data-memory access path of a small 8-bit controller core. It holds a 16-bit data pointer, kept as a high byte and a low byte, and an 8-bit page register. For each access, the core chooses one of two ways to form the address. In pointer mode the 16-bit pointer is the address. In paged mode the page register supplies the upper byte and an 8-bit register operand from the core supplies the lower byte.

Addresses below 4096 reach a 4 KB on-chip RAM. Every other address is sent to a simple external memory bus. That bus has a chip select, separate read and write strobes, an address, write data and read data.

The core controls the block through several inputs:
- a register-write strobe with a select code;
- a whole-pointer load;
- read and write strobes;
- the mode bit, the operand and the write data.

Read data comes back one clock after the read strobe, from either source. Data that goes to the RAM by default is never sent to program storage.

Top module: `xdata_pager`

## Requirements
- R1: While reset is active, and after it is released, the pointer and page registers are zero. The external bus outputs are zero, `acc_rvalid` is low and `acc_rdata` is zero. Reset is asserted asynchronously and released through two flops.
- R2: A register write with `reg_wr` updates the byte picked by `reg_sel` at the next clock edge. The codes are 0 for pointer low, 1 for pointer high and 2 for page. `reg_rdata` shows the byte picked by `reg_sel`, and code 3 reads zero.
- R3: `ptr_load` loads `ptr_load_val` into the pointer, with bits 15:8 going to the high byte. In the same cycle it overrides any byte write to the pointer, while a page write in that cycle still takes effect.
- R4: With `acc_paged` low, the effective address is {pointer high, pointer low}.
- R5: With `acc_paged` high, the effective address is {page, `acc_opnd`}.
- R6: Addresses 0x0000 to 0x0FFF go to the on-chip RAM, and the external bus outputs stay zero. A write stores its data at the clock edge that samples it. A read raises `acc_rvalid` and presents the stored byte on `acc_rdata` one cycle later.
- R7: Any other address drives the external bus in the same cycle as the access. `ext_cs` is high, `ext_addr` carries the address, and exactly one of `ext_we` or `ext_re` is high. `ext_wdata` carries the data for writes and is zero otherwise. For a read, `ext_rdata` is sampled at that edge and returned on `acc_rdata` one cycle later with `acc_rvalid`.
- R8: Both modes reach the same byte when they form the same address.
- R9: An access in the same cycle as a register write or a pointer load uses the register values from before that write.
- R10: If `acc_rd` and `acc_wr` are both high, the access is a write only, and `acc_rvalid` stays low in the next cycle.
- R11: With no access, `ext_cs`, `ext_we`, `ext_re`, `ext_addr` and `ext_wdata` are zero. `acc_rdata` is zero whenever `acc_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_sel | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 page, 3 none |
| reg_wdata | input | 8 | Register byte write data |
| ptr_load | input | 1 | Whole-pointer load strobe |
| ptr_load_val | input | 16 | Whole-pointer load value |
| reg_rdata | output | 8 | Byte picked by reg_sel |
| acc_rd | input | 1 | Data memory read strobe |
| acc_wr | input | 1 | Data memory write strobe |
| acc_paged | input | 1 | 1 selects paged mode, 0 pointer mode |
| acc_opnd | input | 8 | Register operand, low address byte in paged mode |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, one cycle after the read |
| acc_rvalid | output | 1 | Read data valid |
| ext_cs | output | 1 | External bus chip select |
| ext_we | output | 1 | External write strobe |
| ext_re | output | 1 | External read strobe |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data, sampled on the read cycle |

## Verification
Each result is due at a different cycle after its stimulus:
- The external chip select, strobes, address and write data depend only on the present inputs and registers, so they are due in the same cycle as the access.
- Read data and `acc_rvalid` are due one edge after the read.
- Register writes appear on `reg_rdata` and in the next address one edge after the write.

The bench drives every input just after a falling edge and compares 2 ns later, before the next rising edge. Only then does it advance its reference model by one edge, so each expected value belongs to exactly the cycle it is compared in.

// File: rtl/xdp_pkg.sv
`timescale 1ns/1ps
package xdp_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_PAGE   = 2'd2,
    SEL_NONE   = 2'd3
  } xdp_sel_e;

  typedef struct packed {
    logic cs;
    logic we;
    logic re;
  } xdp_bus_ctl_t;
endpackage

// File: rtl/xdp_regs.sv
`timescale 1ns/1ps
module xdp_regs #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_sel,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  ptr_load,
  input  logic [2*DATA_W-1:0]   ptr_load_val,
  output logic [2*DATA_W-1:0]   ptr_q,
  output logic [DATA_W-1:0]     page_q,
  output logic [DATA_W-1:0]     reg_rdata
);
  import xdp_pkg::*;

  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d, page_d;
  logic              lo_en, hi_en, page_en;
  xdp_sel_e          sel;

  assign sel = xdp_sel_e'(reg_sel);

  always_comb begin
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    page_en = 1'b0;
    lo_d    = lo_q;
    hi_d    = hi_q;
    page_d  = page_q;
    if (ptr_load) begin
      lo_en = 1'b1;
      hi_en = 1'b1;
      lo_d  = ptr_load_val[DATA_W-1:0];
      hi_d  = ptr_load_val[2*DATA_W-1:DATA_W];
    end else if (reg_wr && sel == SEL_PTR_LO) begin
      lo_en = 1'b1;
      lo_d  = reg_wdata;
    end else if (reg_wr && sel == SEL_PTR_HI) begin
      hi_en = 1'b1;
      hi_d  = reg_wdata;
    end
    if (reg_wr && sel == SEL_PAGE) begin
      page_en = 1'b1;
      page_d  = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      page_q <= '0;
    end else begin
      if (lo_en)   lo_q   <= lo_d;
      if (hi_en)   hi_q   <= hi_d;
      if (page_en) page_q <= page_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_PTR_LO: reg_rdata = lo_q;
      SEL_PTR_HI: reg_rdata = hi_q;
      SEL_PAGE:   reg_rdata = page_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign ptr_q = {hi_q, lo_q};
endmodule

// File: rtl/xdp_agen.sv
`timescale 1ns/1ps
module xdp_agen #(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 12
) (
  input  logic                  acc_rd,
  input  logic                  acc_wr,
  input  logic                  acc_paged,
  input  logic [DATA_W-1:0]     acc_opnd,
  input  logic [DATA_W-1:0]     acc_wdata,
  input  logic [2*DATA_W-1:0]   ptr,
  input  logic [DATA_W-1:0]     page,
  output logic                  ram_en,
  output logic                  ram_we,
  output logic [RAM_AW-1:0]     ram_addr,
  output xdp_pkg::xdp_bus_ctl_t ext_ctl,
  output logic [2*DATA_W-1:0]   ext_addr,
  output logic [DATA_W-1:0]     ext_wdata
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] eff;
  logic              onchip, active, rd_only;

  assign eff     = acc_paged ? {page, acc_opnd} : ptr;
  assign active  = acc_rd | acc_wr;
  assign rd_only = acc_rd & ~acc_wr;

  generate
    if (RAM_AW < ADDR_W) begin : g_dec
      assign onchip = (eff[ADDR_W-1:RAM_AW] == '0);
    end else begin : g_all
      assign onchip = 1'b1;
    end
  endgenerate

  always_comb begin
    ram_en     = active & onchip;
    ram_we     = acc_wr & onchip;
    ram_addr   = eff[RAM_AW-1:0];
    ext_ctl.cs = active & ~onchip;
    ext_ctl.we = acc_wr & ~onchip;
    ext_ctl.re = rd_only & ~onchip;
    ext_addr   = ext_ctl.cs ? eff : '0;
    ext_wdata  = ext_ctl.we ? acc_wdata : '0;
  end
endmodule

// File: rtl/xdp_ram.sv
`timescale 1ns/1ps
module xdp_ram #(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_en, rd_en;

  assign wr_en = en & we;
  assign rd_en = en & ~we;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= mem[addr];
  end
endmodule

// File: rtl/xdata_pager.sv
`timescale 1ns/1ps
module xdata_pager #(
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                ptr_load,
  input  logic [2*DATA_W-1:0] ptr_load_val,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                acc_rd,
  input  logic                acc_wr,
  input  logic                acc_paged,
  input  logic [DATA_W-1:0]   acc_opnd,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic [DATA_W-1:0]   acc_rdata,
  output logic                acc_rvalid,
  output logic                ext_cs,
  output logic                ext_we,
  output logic                ext_re,
  output logic [2*DATA_W-1:0] ext_addr,
  output logic [DATA_W-1:0]   ext_wdata,
  input  logic [DATA_W-1:0]   ext_rdata
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int RAM_AW = $clog2(RAM_BYTES);

  logic [1:0]            rst_pipe;
  logic                  rst_sync_n;
  logic [ADDR_W-1:0]     ptr_q;
  logic [DATA_W-1:0]     page_q;
  logic                  ram_en, ram_we;
  logic [RAM_AW-1:0]     ram_addr;
  logic [DATA_W-1:0]     ram_q;
  xdp_pkg::xdp_bus_ctl_t ext_ctl;

  logic                  rvalid_q, rvalid_d;
  logic                  src_ext_q, src_ext_d;
  logic [DATA_W-1:0]     ext_q, ext_d;
  logic                  ext_cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  xdp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_q        (ptr_q),
    .page_q       (page_q),
    .reg_rdata    (reg_rdata)
  );

  xdp_agen #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_agen (
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_paged (acc_paged),
    .acc_opnd  (acc_opnd),
    .acc_wdata (acc_wdata),
    .ptr       (ptr_q),
    .page      (page_q),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ext_ctl   (ext_ctl),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata)
  );

  xdp_ram #(.DEPTH(RAM_BYTES), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (ram_en),
    .we      (ram_we),
    .addr    (ram_addr),
    .wdata   (acc_wdata),
    .rdata_q (ram_q)
  );

  assign ext_cs = ext_ctl.cs;
  assign ext_we = ext_ctl.we;
  assign ext_re = ext_ctl.re;

  always_comb begin
    rvalid_d   = acc_rd & ~acc_wr;
    src_ext_d  = ext_ctl.re;
    ext_cap_en = ext_ctl.re;
    ext_d      = ext_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q  <= 1'b0;
      src_ext_q <= 1'b0;
      ext_q     <= '0;
    end else begin
      rvalid_q  <= rvalid_d;
      src_ext_q <= src_ext_d;
      if (ext_cap_en) ext_q <= ext_d;
    end
  end

  assign acc_rvalid = rvalid_q;
  assign acc_rdata  = rvalid_q ? (src_ext_q ? ext_q : ram_q) : '0;
endmodule

// File: rtl/xdp_pager_chk.sv
`timescale 1ns/1ps
module xdp_pager_chk #(
  parameter int DATA_W    = 8,
  parameter int RAM_BYTES = 4096
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ptr_load,
  input logic [2*DATA_W-1:0] ptr_load_val,
  input logic [2*DATA_W-1:0] ptr_q,
  input logic [DATA_W-1:0]   page_q,
  input logic                acc_rd,
  input logic                acc_wr,
  input logic                acc_paged,
  input logic [DATA_W-1:0]   acc_opnd,
  input logic [DATA_W-1:0]   acc_rdata,
  input logic                acc_rvalid,
  input logic                ext_cs,
  input logic                ext_we,
  input logic                ext_re,
  input logic [2*DATA_W-1:0] ext_addr,
  input logic [DATA_W-1:0]   ext_wdata
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int RAM_AW = $clog2(RAM_BYTES);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr_q == $past(ptr_load_val));

  p_ptr_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && !acc_paged) |-> ext_addr == ptr_q);

  p_page_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs && acc_paged) |-> ext_addr == {page_q, acc_opnd});

  p_ext_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs |-> ext_addr[ADDR_W-1:RAM_AW] != '0);

  p_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wr) |=> acc_rvalid);

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs |-> $onehot({ext_we, ext_re}));

  p_wr_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_wr) |=> !acc_rvalid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd || acc_wr) |-> (!ext_cs && !ext_we && !ext_re && ext_addr == '0 && ext_wdata == '0));

  p_rdata_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rvalid |-> acc_rdata == '0);
endmodule

bind xdata_pager xdp_pager_chk #(.DATA_W(DATA_W), .RAM_BYTES(RAM_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ptr_load     (ptr_load),
  .ptr_load_val (ptr_load_val),
  .ptr_q        (ptr_q),
  .page_q       (page_q),
  .acc_rd       (acc_rd),
  .acc_wr       (acc_wr),
  .acc_paged    (acc_paged),
  .acc_opnd     (acc_opnd),
  .acc_rdata    (acc_rdata),
  .acc_rvalid   (acc_rvalid),
  .ext_cs       (ext_cs),
  .ext_we       (ext_we),
  .ext_re       (ext_re),
  .ext_addr     (ext_addr),
  .ext_wdata    (ext_wdata)
);

// File: tb/sim_xdata_pager.sv
`timescale 1ns/1ps
module sim_xdata_pager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = '0;
  logic        ptr_load = 1'b0;
  logic [15:0] ptr_load_val = '0;
  logic [7:0]  reg_rdata;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_paged = 1'b0;
  logic [7:0]  acc_opnd = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        acc_rvalid;
  logic        ext_cs, ext_we, ext_re;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata = '0;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  always #4 clk = ~clk;

  xdata_pager u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .reg_rdata(reg_rdata), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_paged(acc_paged), .acc_opnd(acc_opnd), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .ext_cs(ext_cs),
    .ext_we(ext_we), .ext_re(ext_re), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  // reference model state
  logic [7:0] m_lo = '0, m_hi = '0, m_page = '0;
  logic [7:0] m_mem [int];
  logic       m_rv = 1'b0;
  logic       m_rd_known = 1'b1;
  logic [7:0] m_rd = '0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got 0x%h expected 0x%h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag,
                      input logic rw, input logic [1:0] sel, input logic [7:0] wv,
                      input logic ld, input logic [15:0] lv,
                      input logic rd, input logic wr, input logic pg,
                      input logic [7:0] op, input logic [7:0] dv);
    logic [15:0] eff;
    logic        act, rdo, on, e_cs, e_we, e_re;
    logic [7:0]  e_reg;
    @(negedge clk);
    reg_wr = rw; reg_sel = sel; reg_wdata = wv;
    ptr_load = ld; ptr_load_val = lv;
    acc_rd = rd; acc_wr = wr; acc_paged = pg; acc_opnd = op; acc_wdata = dv;
    ext_rdata = 8'((cyc * 13 + 5) & 255);
    cyc++;
    #2;
    eff  = pg ? {m_page, op} : {m_hi, m_lo};
    act  = rd | wr;
    rdo  = rd & ~wr;
    on   = (eff < 16'h1000);
    e_cs = act & ~on;
    e_we = wr & e_cs;
    e_re = rdo & e_cs;
    case (sel)
      2'd0: e_reg = m_lo;
      2'd1: e_reg = m_hi;
      2'd2: e_reg = m_page;
      default: e_reg = 8'h00;
    endcase
    chk(tag, "ext_cs", 16'(ext_cs), 16'(e_cs));
    chk(tag, "ext_we", 16'(ext_we), 16'(e_we));
    chk(tag, "ext_re", 16'(ext_re), 16'(e_re));
    chk(tag, "ext_addr", ext_addr, e_cs ? eff : 16'h0);
    chk(tag, "ext_wdata", 16'(ext_wdata), e_we ? 16'(dv) : 16'h0);
    chk(tag, "reg_rdata", 16'(reg_rdata), 16'(e_reg));
    chk(tag, "acc_rvalid", 16'(acc_rvalid), 16'(m_rv));
    if (!m_rv) chk(tag, "acc_rdata", 16'(acc_rdata), 16'h0);
    else if (m_rd_known) chk(tag, "acc_rdata", 16'(acc_rdata), 16'(m_rd));
    // advance the model by one rising edge
    if (wr && on) m_mem[int'(eff)] = dv;
    m_rv = rdo;
    m_rd_known = 1'b1;
    m_rd = 8'h00;
    if (rdo) begin
      if (on) begin
        m_rd_known = m_mem.exists(int'(eff));
        if (m_rd_known) m_rd = m_mem[int'(eff)];
      end else begin
        m_rd = ext_rdata;
      end
    end
    if (ld) begin
      m_hi = lv[15:8];
      m_lo = lv[7:0];
    end else if (rw && sel == 2'd0) m_lo = wv;
    else if (rw && sel == 2'd1) m_hi = wv;
    if (rw && sel == 2'd2) m_page = wv;
  endtask

  task automatic idle(input string tag, input logic [1:0] sel);
    step(tag, 1'b0, sel, 8'h00, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic wreg(input string tag, input logic [1:0] sel, input logic [7:0] v);
    step(tag, 1'b1, sel, v, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic acc(input string tag, input logic rd, input logic wr,
                     input logic pg, input logic [7:0] op, input logic [7:0] dv);
    step(tag, 1'b0, 2'd3, 8'h00, 1'b0, 16'h0, rd, wr, pg, op, dv);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    idle("R1", 2'd0);
    idle("R1", 2'd1);
    idle("R1", 2'd2);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 2'd0);
    idle("R1", 2'd1);
    idle("R1", 2'd2);
    idle("R1", 2'd3);

    // R2: byte writes and readback
    wreg("R2", 2'd0, 8'h34);
    wreg("R2", 2'd1, 8'h12);
    wreg("R2", 2'd2, 8'h12);
    idle("R2", 2'd0);
    idle("R2", 2'd1);
    idle("R2", 2'd2);
    idle("R2", 2'd3);

    // R4 and R7: pointer-mode external write to 0x1234
    acc("R4", 1'b0, 1'b1, 1'b0, 8'h00, 8'hC3);
    // R5, R7 and R8: paged external read of the same address
    acc("R5", 1'b1, 1'b0, 1'b1, 8'h34, 8'h00);
    idle("R7", 2'd3);

    // R3 and R6: on-chip write via the pointer, paged read back (R8)
    step("R3", 1'b0, 2'd3, 8'h00, 1'b1, 16'h0ABC, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    acc("R6", 1'b0, 1'b1, 1'b0, 8'h00, 8'h5A);
    wreg("R8", 2'd2, 8'h0A);
    acc("R8", 1'b1, 1'b0, 1'b1, 8'hBC, 8'h00);
    idle("R8", 2'd3);

    // R3: load overrides a same-cycle byte write, page write still lands
    step("R3", 1'b1, 2'd0, 8'hFF, 1'b1, 16'h0123, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    idle("R3", 2'd0);
    idle("R3", 2'd1);
    step("R3", 1'b1, 2'd2, 8'h0F, 1'b1, 16'h0456, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    idle("R3", 2'd2);
    idle("R3", 2'd0);

    // R9: same-cycle register writes use the old values
    step("R9", 1'b0, 2'd3, 8'h00, 1'b1, 16'h4010, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    step("R9", 1'b1, 2'd1, 8'h50, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
    step("R9", 1'b0, 2'd3, 8'h00, 1'b1, 16'h0ABC, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11);
    step("R9", 1'b1, 2'd0, 8'h00, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h77);
    wreg("R9", 2'd2, 8'h0A);
    acc("R9", 1'b1, 1'b0, 1'b1, 8'hBC, 8'h00);
    idle("R9", 2'd3);

    // R10: read and write together act as a write
    acc("R10", 1'b1, 1'b1, 1'b1, 8'hBC, 8'h99);
    idle("R10", 2'd3);
    acc("R10", 1'b1, 1'b0, 1'b1, 8'hBC, 8'h00);
    wreg("R10", 2'd2, 8'h80);
    acc("R10", 1'b1, 1'b1, 1'b1, 8'h01, 8'h66);
    idle("R11", 2'd3);

    // mixed traffic exercising R4-R11 together
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [15:0] lv;
      r  = $urandom();
      lv = {(r[3] ? 4'h0 : r[7:4]), r[19:8]};
      step("R6_R7_mix", r[20] & r[21], r[23:22], {(r[24] ? 4'h0 : r[11:8]), r[7:4]},
           r[25] & r[26], lv, r[27], r[28] & r[29], r[30], r[19:12], r[15:8]);
    end
    idle("R11", 2'd3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule